// File: doc/BRIEF.md
# Synchronous Half-Duplex Shift Port

This block moves single bytes to or from external shift registers over two wires. One output carries a shift clock that rests high when the port is idle. A second, bidirectional line carries the data. During a transmit the port drives that line. During a receive it samples the line. Only one direction is active at a time. Bytes go least significant bit first.

A single-cycle rate enable (`tick`) sets the shift rate. Each enabled cycle advances the shift clock by one half period, so one bit takes two enabled cycles. A transfer starts only when the port is idle. When the eighth clock pulse ends, the matching done flag is set and stays set until it is cleared. The received byte is held on its own output once the transfer completes.

Top module: `sync_shift_port`

## Requirements
- R1: After synchronous reset the shift clock is 1, the data output and its enable are 0, both done flags are 0, and the received byte is 0.
- R2: A transfer accepted while idle produces exactly eight pulses on the shift clock. Each pulse is one low phase followed by one high phase, and each phase ends on an enabled cycle. The clock then rests high.
- R3: In a transmit, bit k of the loaded byte (bit 0 first) is on the data output at the k-th rising edge of the shift clock. After the transfer is accepted, the data output changes only in the cycle where the shift clock falls.
- R4: In a receive, the data input is sampled at each rising edge of the shift clock. The first sample becomes bit 0 of the received byte. The received byte is updated in the cycle of the eighth rising edge.
- R5: The data output enable is 1 from the cycle after a transmit is accepted until the cycle of its eighth rising edge. It is 0 at all other times, including throughout any receive.
- R6: The transmit done flag (for a transmit) or the receive done flag (for a receive) becomes 1 in the cycle of the eighth rising edge. It then stays 1 until a cycle with `done_clr` high. A set in the same cycle as a clear wins.
- R7: A start request of either kind that arrives while a transfer is active is ignored. It does not change the bits sent, the pulse count or either done flag.
- R8: If both start requests are high together while idle, the port performs a transmit.
- R9: The shift clock changes level only in cycles that follow a cycle with `tick` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Rate enable; one shift-clock half period per enabled cycle |
| start_tx | input | 1 | Request to transmit `tx_data` |
| tx_data | input | DATA_W | Byte to transmit |
| start_rx | input | 1 | Request to receive a byte |
| done_clr | input | 1 | Clears both done flags |
| data_in | input | 1 | Data line input (sampled on receive) |
| sck_o | output | 1 | Shift clock, idles high |
| data_o | output | 1 | Data line output value |
| data_oe | output | 1 | Data line output enable |
| rx_data | output | DATA_W | Last received byte |
| tx_done | output | 1 | Sticky transmit complete flag |
| rx_done | output | 1 | Sticky receive complete flag |

## Verification
The assertions assume that `data_in` does not change in a cycle where the shift clock rises. They also assume that `tick` is a plain level sampled on each edge, with no special relation to the start requests. The stimulus draws `tick` at random on every cycle. It models the external shift register by changing `data_in` only after it has seen the shift clock go low, so the line is already stable when the next rising edge samples it. The stimulus also issues start requests in the middle of transfers to exercise the ignore rule.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [1:0] {
    SPS_IDLE = 2'd0,
    SPS_TX   = 2'd1,
    SPS_RX   = 2'd2
  } sps_mode_e;
endpackage

// File: rtl/sps_clkgen.sv
// Shift clock phase and pulse counter.
module sps_clkgen #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic busy,
  input  logic load,
  output logic sck,
  output logic fall_now,
  output logic rise_now,
  output logic last_rise
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] cnt_q;

  assign fall_now  = busy && tick && sck;
  assign rise_now  = busy && tick && !sck;
  assign last_rise = rise_now && (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck   <= 1'b1;
      cnt_q <= '0;
    end else if (load) begin
      sck   <= 1'b1;
      cnt_q <= '0;
    end else if (fall_now) begin
      sck <= 1'b0;
    end else if (rise_now) begin
      sck   <= 1'b1;
      cnt_q <= last_rise ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sps_shifter.sv
// Shared shift register for both directions.
module sps_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_tx,
  input  logic              load_rx,
  input  logic              is_tx,
  input  logic              fall_now,
  input  logic              rise_now,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              data_in,
  output logic              dout,
  output logic [DATA_W-1:0] sh_next
);
  logic [DATA_W-1:0] sh_q;
  logic              fill_bit;

  assign fill_bit = is_tx ? 1'b0 : data_in;

  generate
    if (DATA_W > 1) begin : g_wide
      assign sh_next = {fill_bit, sh_q[DATA_W-1:1]};
    end else begin : g_narrow
      assign sh_next = fill_bit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      dout <= 1'b0;
    end else if (load_tx) begin
      sh_q <= tx_data;
      dout <= tx_data[0];
    end else if (load_rx) begin
      sh_q <= '0;
      dout <= 1'b0;
    end else begin
      if (fall_now && is_tx) dout <= sh_q[0];
      if (rise_now)          sh_q <= sh_next;
    end
  end
endmodule

// File: rtl/sps_flags.sv
// Sticky completion flags.
module sps_flags (
  input  logic clk,
  input  logic rst,
  input  logic set_tx,
  input  logic set_rx,
  input  logic clr,
  output logic tx_done,
  output logic rx_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      if (set_tx)   tx_done <= 1'b1;
      else if (clr) tx_done <= 1'b0;
      if (set_rx)   rx_done <= 1'b1;
      else if (clr) rx_done <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start_tx,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              start_rx,
  input  logic              done_clr,
  input  logic              data_in,
  output logic              sck_o,
  output logic              data_o,
  output logic              data_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_done,
  output logic              rx_done
);
  import sps_pkg::*;

  sps_mode_e         mode_q;
  logic              idle, busy, is_tx;
  logic              acc_tx, acc_rx;
  logic              fall_now, rise_now, last_rise;
  logic [DATA_W-1:0] sh_next;

  assign idle   = (mode_q == SPS_IDLE);
  assign busy   = !idle;
  assign is_tx  = (mode_q == SPS_TX);
  assign acc_tx = idle && start_tx;
  assign acc_rx = idle && start_rx && !start_tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= SPS_IDLE;
      data_oe <= 1'b0;
      rx_data <= '0;
    end else if (acc_tx) begin
      mode_q  <= SPS_TX;
      data_oe <= 1'b1;
    end else if (acc_rx) begin
      mode_q  <= SPS_RX;
      data_oe <= 1'b0;
    end else if (last_rise) begin
      mode_q  <= SPS_IDLE;
      data_oe <= 1'b0;
      if (!is_tx) rx_data <= sh_next;
    end
  end

  sps_clkgen #(.DATA_W(DATA_W)) u_clk (
    .clk(clk), .rst(rst), .tick(tick), .busy(busy),
    .load(acc_tx || acc_rx), .sck(sck_o),
    .fall_now(fall_now), .rise_now(rise_now), .last_rise(last_rise)
  );

  sps_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk(clk), .rst(rst), .load_tx(acc_tx), .load_rx(acc_rx),
    .is_tx(is_tx), .fall_now(fall_now), .rise_now(rise_now),
    .tx_data(tx_data), .data_in(data_in), .dout(data_o), .sh_next(sh_next)
  );

  sps_flags u_flags (
    .clk(clk), .rst(rst),
    .set_tx(last_rise && is_tx), .set_rx(last_rise && !is_tx),
    .clr(done_clr), .tx_done(tx_done), .rx_done(rx_done)
  );
endmodule

// File: rtl/sps_checker.sv
module sps_checker (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              done_clr,
  input logic              sck_o,
  input logic              data_o,
  input logic              data_oe,
  input logic              tx_done,
  input logic              rx_done,
  input sps_pkg::sps_mode_e mode_q
);
  import sps_pkg::*;

  a_r5_no_drive_on_rx: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SPS_RX) |-> !data_oe);

  a_r2_idle_clock_high: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SPS_IDLE) |-> sck_o);

  a_r3_data_held_while_high: assert property (@(posedge clk) disable iff (rst)
    (sck_o && $past(sck_o) && data_oe && $past(data_oe)) |-> $stable(data_o));

  a_r6_tx_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> (sck_o && !data_oe));

  a_r6_tx_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !done_clr) |=> tx_done);

  a_r6_rx_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !done_clr) |=> rx_done);

  a_r9_clock_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sck_o));
endmodule

bind sync_shift_port sps_checker u_chk (
  .clk(clk), .rst(rst), .tick(tick), .done_clr(done_clr),
  .sck_o(sck_o), .data_o(data_o), .data_oe(data_oe),
  .tx_done(tx_done), .rx_done(rx_done), .mode_q(mode_q)
);

// File: tb/sync_shift_port_test.sv
module sync_shift_port_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic         start_tx = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         start_rx = 1'b0;
  logic         done_clr = 1'b0;
  logic         data_in = 1'b0;
  logic         sck_o, data_o, data_oe, tx_done, rx_done;
  logic [W-1:0] rx_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  always @(posedge clk) tick <= (($urandom % 3) == 0);

  sync_shift_port #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .tick(tick), .start_tx(start_tx), .tx_data(tx_data),
    .start_rx(start_rx), .done_clr(done_clr), .data_in(data_in),
    .sck_o(sck_o), .data_o(data_o), .data_oe(data_oe), .rx_data(rx_data),
    .tx_done(tx_done), .rx_done(rx_done)
  );

  function automatic int pulse_count_expected();
    return W;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  // kind: 0 transmit, 1 receive, 2 both requests (transmit expected)
  task automatic transfer(input int kind, input logic [W-1:0] val, input bit poke);
    logic [W-1:0] got = '0;
    int falls = 0, rises = 0, wait_cyc = 0, poke_left = 0;
    bit oe_bad = 0, r9_bad = 0, other_bad = 0;
    logic prev_sck, prev_tick;
    bit expect_tx = (kind != 1);
    @(negedge clk);
    start_tx = (kind != 1);
    start_rx = (kind != 0);
    tx_data  = val;
    @(negedge clk);
    start_tx = 1'b0; start_rx = 1'b0; tx_data = ~val;
    prev_sck = sck_o; prev_tick = tick;
    while (!(expect_tx ? tx_done : rx_done) && wait_cyc < 20000) begin
      @(negedge clk);
      wait_cyc++;
      if (poke_left > 0) begin
        poke_left--;
        if (poke_left == 0) begin start_tx = 1'b0; start_rx = 1'b0; end
      end
      if (sck_o !== prev_sck && !prev_tick) r9_bad = 1;
      if (prev_sck && !sck_o) begin
        falls++;
        if (!expect_tx && falls <= W) data_in = val[falls-1];
        if (poke && falls == 3) begin
          start_tx = 1'b1; start_rx = 1'b1; poke_left = 1;
        end
      end
      if (!prev_sck && sck_o) begin
        rises++;
        if (expect_tx && rises <= W) got[rises-1] = data_o;
      end
      if (expect_tx && !data_oe && !(expect_tx ? tx_done : rx_done)) oe_bad = 1;
      if (!expect_tx && data_oe) oe_bad = 1;
      if (expect_tx ? rx_done : tx_done) other_bad = 1;
      prev_sck = sck_o; prev_tick = tick;
    end
    start_tx = 1'b0; start_rx = 1'b0;
    check("R2 transfer finished (watchdog)", 32'(wait_cyc < 20000), 32'd1);
    check("R2 low pulses", 32'(falls), 32'(pulse_count_expected()));
    check("R2 rising edges", 32'(rises), 32'(pulse_count_expected()));
    check("R9 clock moves only after tick", 32'(r9_bad), 32'd0);
    check("R5 output enable window", 32'(oe_bad), 32'd0);
    check("R6 only matching flag set", 32'(other_bad), 32'd0);
    if (expect_tx) begin
      check(kind == 2 ? "R8 both starts transmit" : (poke ? "R7 ignored start keeps bits" : "R3 transmitted bits LSB first"),
            32'(got), 32'(val));
    end else begin
      check(poke ? "R7 ignored start keeps byte" : "R4 received byte LSB first", 32'(rx_data), 32'(val));
    end
    @(negedge clk);
    check("R5 enable dropped at end", 32'(data_oe), 32'd0);
    check("R2 clock rests high", 32'(sck_o), 32'd1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset clock", 32'(sck_o), 32'd1);
    check("R1 reset enable", 32'(data_oe), 32'd0);
    check("R1 reset data", 32'(data_o), 32'd0);
    check("R1 reset flags", 32'({tx_done, rx_done}), 32'd0);
    check("R1 reset rx byte", 32'(rx_data), 32'd0);

    transfer(0, 8'h01, 0); clear_flags();
    transfer(0, 8'h80, 0); clear_flags();
    transfer(0, 8'hA5, 0); clear_flags();
    transfer(0, 8'h00, 0); clear_flags();
    transfer(0, 8'hFF, 0); clear_flags();
    transfer(1, 8'h5A, 0); clear_flags();
    transfer(1, 8'h81, 0); clear_flags();
    for (int i = 0; i < 6; i++) begin
      transfer(i % 2, 8'($urandom), 0);
      clear_flags();
    end

    transfer(0, 8'h3C, 1);
    check("R7 no receive flag after ignored start", 32'(rx_done), 32'd0);
    clear_flags();
    transfer(1, 8'hC3, 1);
    check("R7 no transmit flag after ignored start", 32'(tx_done), 32'd0);
    clear_flags();

    transfer(2, 8'h96, 0);
    check("R8 receive flag stays clear", 32'(rx_done), 32'd0);

    repeat (10) @(negedge clk);
    check("R6 transmit flag sticky", 32'(tx_done), 32'd1);
    clear_flags();
    check("R6 flags cleared", 32'({tx_done, rx_done}), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule